// File: doc/BRIEF.md
# APB5 Requester with Clock-Wake Signalling

This block turns commands from a local valid/ready port into APB5 transfers. Each command carries an address, a write flag, write data and two user attributes. One attribute goes with every transfer. The other goes only with writes. The block runs the Setup and Access phases on the bus. It returns read data, the completer's user attributes and the error flag to the local side as a one-cycle response pulse.

Its main job is the wake request sent to the completer's clock controller. That output comes straight from a flip-flop clocked by the bus clock, so it cannot glitch. When the bus has been idle, the wake request rises a programmable number of cycles (`WAKE_LEAD`) before PSEL. Once it overlaps PSEL it stays high until the cycle in which PREADY completes the transfer. It falls only when no further command is waiting. Commands presented back to back keep the wake request high across transfer boundaries. If a command is withdrawn during the lead time, the wake request goes low again and no transfer takes place.

Top module: `apb5_wake_req`

## Requirements
- R1: While rst_ni is low, pwakeup_o, psel_o and penable_o are low.
- R2: Starting from idle, pwakeup_o rises exactly WAKE_LEAD cycles before psel_o rises. psel_o never rises unless pwakeup_o was already high in the cycle before.
- R3: In any cycle with pwakeup_o and psel_o high and no completion (completion means psel_o, penable_o and pready_i all high), pwakeup_o is high in the next cycle.
- R4: After a completion with cmd_valid_i low, pwakeup_o and psel_o are low in the next cycle. pwakeup_o never falls in a cycle where psel_o is high.
- R5: After a completion with cmd_valid_i high, the next cycle is a Setup cycle (psel_o=1, penable_o=0) for that command, and pwakeup_o stays high.
- R6: A Setup cycle lasts exactly one cycle and is followed by Access (psel_o=1, penable_o=1). Access repeats while pready_i is low.
- R7: paddr_o, pwrite_o, pwdata_o and pauser_o equal the accepted command and stay constant from Setup until completion. Commands reach the bus in acceptance order, and a command is accepted in a cycle where cmd_valid_i and cmd_ready_o are both high.
- R8: pwuser_o carries the command's write attribute for writes and is all-zero for reads.
- R9: One cycle after each completion, rsp_valid_o is high for exactly one cycle. In that cycle rsp_rdata_o equals prdata_i, rsp_buser_o equals pbuser_i and rsp_err_o equals pslverr_i, all as sampled at completion. rsp_ruser_o equals pruser_i for reads and is zero for writes.
- R10: If cmd_valid_i drops during the lead time, pwakeup_o returns low and psel_o does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_auser_i | input | AUSER_W | Per-transfer user attribute |
| cmd_wuser_i | input | WUSER_W | Write-only user attribute |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | DATA_W | Returned read data |
| rsp_ruser_o | output | RUSER_W | Read user attribute (zero for writes) |
| rsp_buser_o | output | BUSER_W | Completion user attribute |
| rsp_err_o | output | 1 | Completer error, passed through |
| psel_o | output | 1 | Bus select |
| penable_o | output | 1 | Access phase marker |
| paddr_o | output | ADDR_W | Bus address |
| pwrite_o | output | 1 | Bus direction |
| pwdata_o | output | DATA_W | Bus write data |
| pauser_o | output | AUSER_W | Bus request user attribute |
| pwuser_o | output | WUSER_W | Bus write user attribute |
| pwakeup_o | output | 1 | Flop-driven wake request |
| prdata_i | input | DATA_W | Completer read data |
| pready_i | input | 1 | Completer ready |
| pslverr_i | input | 1 | Completer error |
| pruser_i | input | RUSER_W | Completer read user attribute |
| pbuser_i | input | BUSER_W | Completer completion user attribute |

## Verification
A sequencer stuck in its lead state shows up as a wake-to-select gap that differs from WAKE_LEAD at the very first select edge after idle. A sequencer that forgets a waiting command drops the wake request, or adds an idle cycle, in the cycle right after completion. A payload register that loads at the wrong time changes the address or the user attributes in the middle of Access, or shows a command other than the next queued one at Setup. A response register that is stale or mis-steered shows up one cycle after completion, as a missing pulse, a repeated pulse or a read attribute that is not cleared on a write.

// File: rtl/apb5_wake_pkg.sv
package apb5_wake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_SETUP  = 2'd2,
    ST_ACCESS = 2'd3
  } phase_e;
endpackage

// File: rtl/apb5_wake_fsm.sv
module apb5_wake_fsm
  import apb5_wake_pkg::*;
#(
  parameter int WAKE_LEAD = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_valid_i,
  input  logic   pready_i,
  output phase_e state_o,
  output logic   accept_o,
  output logic   done_o,
  output logic   busy_d_o
);
  localparam int CW = (WAKE_LEAD > 1) ? $clog2(WAKE_LEAD) : 1;
  localparam logic [CW-1:0] LEAD_INIT = CW'(WAKE_LEAD - 1);

  phase_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    accept_o = 1'b0;
    done_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) begin
        state_d = ST_WAKE;
        cnt_d   = LEAD_INIT;
      end
      ST_WAKE: begin
        if (!cmd_valid_i) state_d = ST_IDLE;   // false wakeup
        else if (cnt_q == '0) begin
          accept_o = 1'b1;
          state_d  = ST_SETUP;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_SETUP: state_d = ST_ACCESS;
      ST_ACCESS: if (pready_i) begin
        done_o = 1'b1;
        if (cmd_valid_i) begin
          accept_o = 1'b1;
          state_d  = ST_SETUP;
        end else state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o  = state_q;
  assign busy_d_o = (state_d != ST_IDLE);

  p_false_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && !cmd_valid_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/apb5_wake_flop.sv
module apb5_wake_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_d_i,
  input  logic psel_i,
  input  logic penable_i,
  input  logic pready_i,
  output logic pwakeup_o
);
  // Registered output only: routed to a clock controller.
  logic wake_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= wake_d_i;
  end
  assign pwakeup_o = wake_q;

  p_wake_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_q && psel_i && !(penable_i && pready_i)) |=> wake_q);
  p_wake_leads_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psel_i) |-> (wake_q && $past(wake_q)));
  p_no_drop_in_xfer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_q) |-> !psel_i);
endmodule

// File: rtl/apb5_wake_cmd_reg.sv
module apb5_wake_cmd_reg #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int AUSER_W = 8,
  parameter int WUSER_W = 8,
  parameter int RUSER_W = 8,
  parameter int BUSER_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               done_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic               cmd_write_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [AUSER_W-1:0] cmd_auser_i,
  input  logic [WUSER_W-1:0] cmd_wuser_i,
  input  logic [DATA_W-1:0]  prdata_i,
  input  logic               pslverr_i,
  input  logic [RUSER_W-1:0] pruser_i,
  input  logic [BUSER_W-1:0] pbuser_i,
  output logic [ADDR_W-1:0]  paddr_o,
  output logic               pwrite_o,
  output logic [DATA_W-1:0]  pwdata_o,
  output logic [AUSER_W-1:0] pauser_o,
  output logic [WUSER_W-1:0] pwuser_o,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic [RUSER_W-1:0] rsp_ruser_o,
  output logic [BUSER_W-1:0] rsp_buser_o,
  output logic               rsp_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o  <= '0;
      pwrite_o <= 1'b0;
      pwdata_o <= '0;
      pauser_o <= '0;
      pwuser_o <= '0;
    end else if (accept_i) begin
      paddr_o  <= cmd_addr_i;
      pwrite_o <= cmd_write_i;
      pwdata_o <= cmd_wdata_i;
      pauser_o <= cmd_auser_i;
      pwuser_o <= cmd_write_i ? cmd_wuser_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_ruser_o <= '0;
      rsp_buser_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= done_i;
      if (done_i) begin
        rsp_rdata_o <= prdata_i;
        rsp_ruser_o <= pwrite_o ? '0 : pruser_i;
        rsp_buser_o <= pbuser_i;
        rsp_err_o   <= pslverr_i;
      end
    end
  end
endmodule

// File: rtl/apb5_wake_req.sv
module apb5_wake_req
  import apb5_wake_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int AUSER_W   = 8,
  parameter int WUSER_W   = 8,
  parameter int RUSER_W   = 8,
  parameter int BUSER_W   = 4,
  parameter int WAKE_LEAD = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic               cmd_write_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [AUSER_W-1:0] cmd_auser_i,
  input  logic [WUSER_W-1:0] cmd_wuser_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic [RUSER_W-1:0] rsp_ruser_o,
  output logic [BUSER_W-1:0] rsp_buser_o,
  output logic               rsp_err_o,
  output logic               psel_o,
  output logic               penable_o,
  output logic [ADDR_W-1:0]  paddr_o,
  output logic               pwrite_o,
  output logic [DATA_W-1:0]  pwdata_o,
  output logic [AUSER_W-1:0] pauser_o,
  output logic [WUSER_W-1:0] pwuser_o,
  output logic               pwakeup_o,
  input  logic [DATA_W-1:0]  prdata_i,
  input  logic               pready_i,
  input  logic               pslverr_i,
  input  logic [RUSER_W-1:0] pruser_i,
  input  logic [BUSER_W-1:0] pbuser_i
);
  if (AUSER_W < 1 || AUSER_W > 128) begin : g_bad_auser
    $error("AUSER_W must be 1..128");
  end
  if (WUSER_W < 1 || WUSER_W > DATA_W / 2) begin : g_bad_wuser
    $error("WUSER_W must be 1..DATA_W/2");
  end
  if (WAKE_LEAD < 1) begin : g_bad_lead
    $error("WAKE_LEAD must be at least 1");
  end

  phase_e state;
  logic   accept, done, busy_d;

  apb5_wake_fsm #(.WAKE_LEAD(WAKE_LEAD)) u_fsm (
    .clk_i, .rst_ni, .cmd_valid_i, .pready_i,
    .state_o(state), .accept_o(accept), .done_o(done), .busy_d_o(busy_d)
  );

  assign psel_o      = (state == ST_SETUP) || (state == ST_ACCESS);
  assign penable_o   = (state == ST_ACCESS);
  assign cmd_ready_o = accept;

  apb5_wake_flop u_wake (
    .clk_i, .rst_ni, .wake_d_i(busy_d),
    .psel_i(psel_o), .penable_i(penable_o), .pready_i,
    .pwakeup_o
  );

  apb5_wake_cmd_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUSER_W(AUSER_W),
    .WUSER_W(WUSER_W), .RUSER_W(RUSER_W), .BUSER_W(BUSER_W)
  ) u_cmd (
    .clk_i, .rst_ni, .accept_i(accept), .done_i(done),
    .cmd_addr_i, .cmd_write_i, .cmd_wdata_i, .cmd_auser_i, .cmd_wuser_i,
    .prdata_i, .pslverr_i, .pruser_i, .pbuser_i,
    .paddr_o, .pwrite_o, .pwdata_o, .pauser_o, .pwuser_o,
    .rsp_valid_o, .rsp_rdata_o, .rsp_ruser_o, .rsp_buser_o, .rsp_err_o
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_idle_r1: assert (!pwakeup_o && !psel_o && !penable_o);
    end
  end

  p_setup_then_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !penable_o) |=> (psel_o && penable_o));
  p_payload_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && !pready_i) |=> (psel_o && penable_o &&
      $stable(paddr_o) && $stable(pwrite_o) && $stable(pwdata_o) &&
      $stable(pauser_o) && $stable(pwuser_o)));
  p_wuser_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !pwrite_o) |-> (pwuser_o == '0));
  p_rsp_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i) |=> rsp_valid_o);
  p_idle_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i && !cmd_valid_i) |=> (!pwakeup_o && !psel_o));
  p_back_to_back_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && pready_i && cmd_valid_i) |=>
      (psel_o && !penable_o && pwakeup_o));
endmodule

// File: tb/apb5_wake_req_tb.sv
module apb5_wake_req_tb_top;
  localparam int CLK_P = 10;
  localparam int LEAD  = 2;

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic [31:0] wdata;
    logic [7:0]  auser;
    logic [7:0]  wuser;
  } cmd_t;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_P / 2) clk = ~clk;

  logic        cmd_valid, cmd_ready, cmd_write;
  logic [15:0] cmd_addr;
  logic [31:0] cmd_wdata;
  logic [7:0]  cmd_auser, cmd_wuser;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [7:0]  rsp_ruser;
  logic [3:0]  rsp_buser;
  logic        psel, penable, pwrite, pwakeup;
  logic [15:0] paddr;
  logic [31:0] pwdata;
  logic [7:0]  pauser, pwuser;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pruser;
  logic [3:0]  pbuser;

  apb5_wake_req #(.WAKE_LEAD(LEAD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_addr_i(cmd_addr),
    .cmd_write_i(cmd_write), .cmd_wdata_i(cmd_wdata), .cmd_auser_i(cmd_auser),
    .cmd_wuser_i(cmd_wuser),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_ruser_o(rsp_ruser),
    .rsp_buser_o(rsp_buser), .rsp_err_o(rsp_err),
    .psel_o(psel), .penable_o(penable), .paddr_o(paddr), .pwrite_o(pwrite),
    .pwdata_o(pwdata), .pauser_o(pauser), .pwuser_o(pwuser), .pwakeup_o(pwakeup),
    .prdata_i(prdata), .pready_i(pready), .pslverr_i(pslverr),
    .pruser_i(pruser), .pbuser_i(pbuser)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_rdata(input logic [15:0] a);
    return {a, ~a};
  endfunction
  function automatic logic [7:0] f_ruser(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  function automatic logic [3:0] f_buser(input logic [15:0] a);
    return a[11:8];
  endfunction

  // Completer model
  always @(negedge clk) begin
    if (psel && penable) pready = ($urandom_range(0, 2) != 0);
    else                 pready = 1'($urandom_range(0, 1));
    prdata  = f_rdata(paddr);
    pruser  = f_ruser(paddr);
    pbuser  = f_buser(paddr);
    pslverr = paddr[5];
  end

  // Monitor
  cmd_t cmd_q[$];
  cmd_t rsp_q[$];
  logic prev_psel = 0, prev_pen = 0, prev_wake = 0;
  logic [15:0] prev_addr;
  logic [31:0] prev_wdata;
  logic [7:0]  prev_auser, prev_wuser;
  logic        prev_wr;
  int lead_cnt = 0;
  int sel_rises = 0;
  int wake_rises = 0;

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      automatic bit comp = prev_psel && prev_pen && pready;
      if (prev_wake && prev_psel && !comp)
        chk(pwakeup, "R3 wake held in transfer", pwakeup, 1);
      if (prev_psel && !prev_pen)
        chk(psel && penable, "R6 setup->access", {psel, penable}, 2'b11);
      if (prev_psel && prev_pen && !pready) begin
        chk(psel && penable, "R6 access held", {psel, penable}, 2'b11);
        chk(paddr == prev_addr && pwrite == prev_wr && pwdata == prev_wdata &&
            pauser == prev_auser && pwuser == prev_wuser, "R7 payload stable",
            {paddr, pauser, pwuser}, {prev_addr, prev_auser, prev_wuser});
      end
      if (prev_wake && !pwakeup)
        chk(!psel, "R4 no drop with psel", psel, 0);
      if (comp) begin
        if (cmd_valid)
          chk(psel && !penable && pwakeup, "R5 back-to-back setup",
              {psel, penable, pwakeup}, 3'b101);
        else
          chk(!pwakeup && !psel, "R4 idle after last", {pwakeup, psel}, 2'b00);
        if (rsp_q.size() == 0) chk(0, "R9 response without command", 1, 0);
        else begin
          automatic cmd_t c = rsp_q.pop_front();
          chk(rsp_valid, "R9 rsp pulse", rsp_valid, 1);
          chk(rsp_rdata == f_rdata(c.addr), "R9 rdata", rsp_rdata, f_rdata(c.addr));
          chk(rsp_ruser == (c.wr ? 8'h00 : f_ruser(c.addr)), "R9 ruser",
              rsp_ruser, c.wr ? 8'h00 : f_ruser(c.addr));
          chk(rsp_buser == f_buser(c.addr) && rsp_err == c.addr[5], "R9 buser/err",
              {rsp_buser, rsp_err}, {f_buser(c.addr), c.addr[5]});
        end
      end else if (rsp_valid) chk(0, "R9 spurious rsp", 1, 0);
      if (psel && !prev_psel) begin
        sel_rises++;
        chk(lead_cnt == LEAD, "R2 wake lead", lead_cnt, LEAD);
      end
      if (pwakeup && !prev_wake) wake_rises++;
      if (psel && !penable) begin
        if (cmd_q.size() == 0) chk(0, "R7 setup without command", 1, 0);
        else begin
          automatic cmd_t c = cmd_q.pop_front();
          chk(paddr == c.addr && pwrite == c.wr && pwdata == c.wdata &&
              pauser == c.auser, "R7 payload at setup", {paddr, pauser},
              {c.addr, c.auser});
          chk(pwuser == (c.wr ? c.wuser : 8'h00), "R8 pwuser",
              pwuser, c.wr ? c.wuser : 8'h00);
          rsp_q.push_back(c);
        end
      end
      if (pwakeup && !psel) lead_cnt++;
      else                  lead_cnt = 0;
    end
    prev_psel = psel; prev_pen = penable; prev_wake = pwakeup;
    prev_addr = paddr; prev_wr = pwrite; prev_wdata = pwdata;
    prev_auser = pauser; prev_wuser = pwuser;
  end

  function automatic cmd_t rand_cmd();
    cmd_t c;
    c.addr  = 16'($urandom);
    c.wr    = 1'($urandom);
    c.wdata = $urandom;
    c.auser = 8'($urandom);
    c.wuser = 8'($urandom);
    return c;
  endfunction

  task automatic present(input cmd_t c);
    cmd_addr = c.addr; cmd_write = c.wr; cmd_wdata = c.wdata;
    cmd_auser = c.auser; cmd_wuser = c.wuser; cmd_valid = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_write = 1'b0;
    cmd_wdata = '0; cmd_auser = '0; cmd_wuser = '0;
    pready = 1'b0; prdata = '0; pruser = '0; pbuser = '0; pslverr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pwakeup && !psel && !penable, "R1 reset idle",
        {pwakeup, psel, penable}, 3'b000);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R10: false wakeup, command withdrawn during lead time
    begin
      automatic int sr = sel_rises;
      automatic int wr = wake_rises;
      present(rand_cmd());
      @(posedge clk); #2;
      cmd_valid = 1'b0;
      repeat (4) @(posedge clk); #2;
      chk(sel_rises == sr, "R10 no select on false wakeup", sel_rises, sr);
      chk(wake_rises == wr + 1 && !pwakeup, "R10 wake pulsed then dropped",
          {wake_rises, pwakeup}, {wr + 1, 1'b0});
    end

    // Mixed random traffic: back-to-back bursts and idle gaps
    for (int i = 0; i < 120; i++) begin
      automatic cmd_t c = rand_cmd();
      if (i < 4) c.wr = i[0];
      cmd_q.push_back(c);
      present(c);
      @(negedge clk); #1;
      while (!cmd_ready) begin @(negedge clk); #1; end
      @(posedge clk); #2;
      if ($urandom_range(0, 2) != 0 && i != 119) continue;
      cmd_valid = 1'b0;
      repeat ($urandom_range(1, 6)) @(posedge clk);
      #2;
    end
    cmd_valid = 1'b0;
    repeat (12) @(posedge clk); #2;
    chk(!pwakeup && !psel, "R4 idle at end", {pwakeup, psel}, 2'b00);
    chk(cmd_q.size() == 0 && rsp_q.size() == 0, "R9 all responses seen",
        cmd_q.size() + rsp_q.size(), 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule